// File: doc/BRIEF.md
# UART Interrupt Identification Prioritizer

This block merges the interrupt conditions of a UART into a single 4-bit identification code and one interrupt request line. Four conditions compete: a receive line error, receive data at or above the FIFO trigger level, a receive character timeout, and an empty transmit holding register. A fixed priority picks the one to report. A set bit 0 in the code means that nothing is pending.

The sticky conditions are held in the block. The line error clears when software reads the line-status register. The timeout clears when software reads the receive buffer. The transmit-empty condition clears when software writes the transmit holding register, or when software reads the identification register while that code is the one shown. The receive-data condition is a level that the FIFO logic supplies. It drops by itself once reads take the FIFO below its trigger level. Each group of sources has an enable bit. A disabled source keeps its pending state but is neither reported nor requested.

Top module: `uart_irq_prio`

## Requirements
- R1: With no enabled source pending, `iid_o` is 4'b0001 and `irq_o` is low. This is also the state during and right after reset.
- R2: A `line_err_i` pulse makes the line error pending. It reports 4'b0110 over every other source when `en_i[2]` is set, and a `lsr_rd_i` strobe clears it in the next cycle.
- R3: While `rx_lvl_i` is high and `en_i[0]` is set, and no enabled line error is pending, `iid_o` is 4'b0100. The code leaves 4'b0100 in the same cycle that `rx_lvl_i` falls.
- R4: A `char_tmo_i` pulse makes the timeout pending. It reports 4'b1100 when `en_i[0]` is set and neither an enabled line error nor receive data is present. It ranks below receive data, and a `rbr_rd_i` strobe clears it.
- R5: A low-to-high change of `thr_empty_i` makes the transmit-empty condition pending. It reports 4'b0010 only when `en_i[1]` is set and no higher source is enabled and pending. With `THRE_SKIP_RESET=1`, an input that is already high when reset ends raises nothing.
- R6: Transmit-empty clears after a `thr_wr_i` strobe. It also clears after an `iid_rd_i` strobe in a cycle where `iid_o` shows 4'b0010. An `iid_rd_i` strobe while another code is shown leaves it pending.
- R7: Clearing `en_i` bits hides sources from `iid_o` and `irq_o` but keeps their pending state. Setting the bit again reports the source, unless it was cleared in the meantime.
- R8: `irq_o` is high exactly when some enabled source is pending. This is the same as `iid_o[0]` being low.
- R9: `iid_o` only ever takes the values 0001, 0110, 0100, 1100 and 0010.
- R10: When a set event and its clear strobe arrive in the same cycle, the condition stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_err_i | input | 1 | Pulse: overrun, parity, framing or break detected |
| rx_lvl_i | input | 1 | Level: receive FIFO at or above trigger |
| char_tmo_i | input | 1 | Pulse: receive character timeout expired |
| thr_empty_i | input | 1 | Level: transmit holding FIFO empty |
| iid_rd_i | input | 1 | Identification register read strobe |
| lsr_rd_i | input | 1 | Line-status register read strobe |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| en_i | input | EN_W | Enables: [0] receive data and timeout, [1] transmit empty, [2] line error |
| iid_o | output | 4 | Identification code |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default `THRE_SKIP_RESET=1`, so holding `thr_empty_i` high through reset exercises the start-up suppression of the transmit-empty event. It also tests the read-clear on a later rising edge of that input. With the fixed 3-bit enable, every mix of masked and unmasked sources is within reach of the random phase. The directed phase walks through priority collisions, the clear strobes that arrive while another code is shown, and same-cycle set and clear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IID_W = 4;

  typedef enum logic [IID_W-1:0] {
    IID_NONE = 4'b0001,
    IID_LINE = 4'b0110,
    IID_RXAV = 4'b0100,
    IID_TMO  = 4'b1100,
    IID_THRE = 4'b0010
  } iid_e;

  typedef struct packed {
    logic line;
    logic rxav;
    logic tmo;
    logic thre;
  } pend_t;
endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (set_i)   pend_q <= 1'b1;
    else if (clr_i)   pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o);
  // R2
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_o);
endmodule

// File: rtl/uart_irq_enc.sv
module uart_irq_enc
  import uart_irq_pkg::*;
#(
  parameter int EN_W = 3
) (
  input  pend_t            pend_i,
  input  logic [EN_W-1:0]  en_i,
  output logic [IID_W-1:0] iid_o,
  output logic             irq_o
);
  pend_t vis;

  always_comb begin
    vis.line = pend_i.line & en_i[2];
    vis.rxav = pend_i.rxav & en_i[0];
    vis.tmo  = pend_i.tmo  & en_i[0];
    vis.thre = pend_i.thre & en_i[1];
  end

  always_comb begin
    if (vis.line)      iid_o = IID_LINE;
    else if (vis.rxav) iid_o = IID_RXAV;
    else if (vis.tmo)  iid_o = IID_TMO;
    else if (vis.thre) iid_o = IID_THRE;
    else               iid_o = IID_NONE;
  end

  assign irq_o = |vis;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int EN_W            = 3,
  parameter bit THRE_SKIP_RESET = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            line_err_i,
  input  logic            rx_lvl_i,
  input  logic            char_tmo_i,
  input  logic            thr_empty_i,
  input  logic            iid_rd_i,
  input  logic            lsr_rd_i,
  input  logic            rbr_rd_i,
  input  logic            thr_wr_i,
  input  logic [EN_W-1:0] en_i,
  output logic [3:0]      iid_o,
  output logic            irq_o
);
  localparam int NSTICKY = 3;
  localparam int S_LINE  = 0;
  localparam int S_TMO   = 1;
  localparam int S_THRE  = 2;

  logic               empty_q;
  logic               thre_rise;
  logic               thre_rd_clr;
  logic [NSTICKY-1:0] set_v, clr_v, pend_v;
  pend_t              pend;
  logic [IID_W-1:0]   iid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) empty_q <= THRE_SKIP_RESET;
    else         empty_q <= thr_empty_i;
  end

  assign thre_rise   = thr_empty_i & ~empty_q;
  // code is sampled in the read cycle, so only a reported THRE is cleared
  assign thre_rd_clr = iid_rd_i & (iid == IID_THRE);

  assign set_v[S_LINE] = line_err_i;
  assign clr_v[S_LINE] = lsr_rd_i;
  assign set_v[S_TMO]  = char_tmo_i;
  assign clr_v[S_TMO]  = rbr_rd_i;
  assign set_v[S_THRE] = thre_rise;
  assign clr_v[S_THRE] = thr_wr_i | thre_rd_clr;

  for (genvar g = 0; g < NSTICKY; g++) begin : g_src
    uart_irq_src u_src (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .pend_o (pend_v[g])
    );
  end

  always_comb begin
    pend.line = pend_v[S_LINE];
    pend.rxav = rx_lvl_i;
    pend.tmo  = pend_v[S_TMO];
    pend.thre = pend_v[S_THRE];
  end

  uart_irq_enc #(.EN_W(EN_W)) u_enc (
    .pend_i (pend),
    .en_i   (en_i),
    .iid_o  (iid),
    .irq_o  (irq_o)
  );

  assign iid_o = iid;

  // R9
  iid_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iid_o inside {IID_NONE, IID_LINE, IID_RXAV, IID_TMO, IID_THRE});
  // R2
  line_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v[S_LINE] && en_i[2]) |-> iid_o == IID_LINE);
  // R8
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iid_o != IID_NONE));
  // R6
  thre_rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iid_rd_i && iid_o == IID_THRE && !thre_rise) |=> !pend_v[S_THRE]);
  // R4
  tmo_below_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_lvl_i && en_i[0]) |-> iid_o != IID_TMO);
endmodule

// File: tb/sim_uart_irq_prio.sv
module sim_uart_irq_prio;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_err = 0, rx_lvl = 0, char_tmo = 0, thr_empty = 1;
  logic iid_rd = 0, lsr_rd = 0, rbr_rd = 0, thr_wr = 0;
  logic [2:0] en = 3'b111;
  logic [3:0] iid;
  logic irq;
  int checks = 0, errors = 0;
  bit m_ls, m_tmo, m_thre, m_prev;

  always #2 clk = ~clk;

  uart_irq_prio u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_err_i(line_err), .rx_lvl_i(rx_lvl),
    .char_tmo_i(char_tmo), .thr_empty_i(thr_empty), .iid_rd_i(iid_rd),
    .lsr_rd_i(lsr_rd), .rbr_rd_i(rbr_rd), .thr_wr_i(thr_wr), .en_i(en),
    .iid_o(iid), .irq_o(irq)
  );

  function automatic logic [3:0] exp_code();
    if (m_ls && en[2])       return 4'b0110;
    else if (rx_lvl && en[0]) return 4'b0100;
    else if (m_tmo && en[0])  return 4'b1100;
    else if (m_thre && en[1]) return 4'b0010;
    else                      return 4'b0001;
  endfunction

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'b0110: return "R2";
      4'b0100: return "R3";
      4'b1100: return "R4";
      4'b0010: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic clear_in();
    line_err = 0; char_tmo = 0; iid_rd = 0; lsr_rd = 0; rbr_rd = 0; thr_wr = 0;
  endtask

  // inputs already driven; compare, advance model, then move to next negedge
  task automatic tick();
    logic [3:0] e;
    bit rise;
    #1;
    e = exp_code();
    chk(tag_of(e), iid, e);
    chk("R8", {3'b0, irq}, {3'b0, e != 4'b0001});
    rise = thr_empty && !m_prev;
    m_ls  = line_err || (m_ls && !lsr_rd);
    m_tmo = char_tmo || (m_tmo && !rbr_rd);
    m_thre = rise || (m_thre && !(thr_wr || (iid_rd && e == 4'b0010)));
    m_prev = thr_empty;
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_ls = 0; m_tmo = 0; m_thre = 0; m_prev = 1;
    repeat (3) @(negedge clk);
    chk("R1", iid, 4'b0001);
    chk("R1", {3'b0, irq}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: empty held high through reset raises nothing
    tick(); chk("R5", iid, 4'b0001);
    // R2 and R4 together, line wins
    line_err = 1; char_tmo = 1; tick();
    tick(); chk("R2", iid, 4'b0110);
    // R6: iid read while line shown leaves others
    iid_rd = 1; tick();
    lsr_rd = 1; tick(); chk("R2", iid, 4'b1100);
    // R3 over R4
    rx_lvl = 1; tick(); chk("R4", iid, 4'b0100);
    rx_lvl = 0; tick(); chk("R3", iid, 4'b1100);
    rbr_rd = 1; tick(); chk("R4", iid, 4'b0001);
    // R5 rise, R6 iid-read clear
    thr_empty = 0; tick(); thr_empty = 1; tick();
    chk("R5", iid, 4'b0010);
    iid_rd = 1; tick(); chk("R6", iid, 4'b0001);
    // R6 write clear, with iid read of another code first
    thr_empty = 0; tick(); thr_empty = 1; char_tmo = 1; tick();
    iid_rd = 1; tick(); chk("R6", iid, 4'b1100);
    rbr_rd = 1; tick(); chk("R6", iid, 4'b0010);
    thr_wr = 1; thr_empty = 0; tick(); chk("R6", iid, 4'b0001);
    // R10 set and clear same cycle
    line_err = 1; lsr_rd = 1; tick(); chk("R10", iid, 4'b0110);
    lsr_rd = 1; tick(); chk("R10", iid, 4'b0001);
    // R7 masking keeps pending
    en = 3'b000; line_err = 1; tick(); chk("R7", iid, 4'b0001);
    chk("R7", {3'b0, irq}, 4'b0);
    en = 3'b100; tick(); chk("R7", iid, 4'b0110);
    lsr_rd = 1; tick();
    en = 3'b111; tick();
    // random phase: every cycle compared to the model (R9 via code match)
    for (int i = 0; i < 4000; i++) begin
      line_err = ($urandom % 16) == 0;
      char_tmo = ($urandom % 16) == 0;
      lsr_rd   = ($urandom % 8) == 0;
      rbr_rd   = ($urandom % 8) == 0;
      thr_wr   = ($urandom % 8) == 0;
      iid_rd   = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) rx_lvl = ~rx_lvl;
      if (($urandom % 6) == 0) thr_empty = ~thr_empty;
      if (($urandom % 32) == 0) en = 3'($urandom);
      tick();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule